// File: doc/BRIEF.md
# Instruction Word Validity Checker

This block examines one 32-bit instruction word for a small load/store processor and decides whether the word is a legal instruction. It splits the word into its opcode, two register selectors and a 17-bit address/immediate field. It works out which of those fields the opcode actually uses, and it applies the legality rules only to the used fields. Bits that the opcode ignores never change the verdict.

The decision logic is combinational and feeds one output register stage. A valid/ready handshake lets the block screen a stream of words. The processor core places it in front of execution, and it can also check words one per cycle with a latency of one clock. When the word is legal, the registered result carries the field-usage flags: whether reg1 and reg2 are read, whether the 17-bit field is an aligned address or a free immediate, and whether the instruction overwrites reg1.

Top module: `instr_word_checker`

## Requirements
- R1: Field positions are opcode = bits 31:27, reg1 = bits 26:22, reg2 = bits 21:17, field = bits 16:0. An opcode value of 22 or more makes the word illegal.
- R2: A register selector that the opcode uses makes the word illegal when its value is 18 or more.
- R3: An opcode that overwrites reg1 is illegal when reg1 is 16 or 17. The compares and store-word read reg1 without writing it, so for them reg1 may be 16 or 17. Any opcode may use 16 or 17 as reg2.
- R4: For load-word (18), store-word (19) and branch (21), the 17-bit field is a byte address, and the word is illegal unless bits 1:0 of that field are zero. For load-immediate (20), every field value from 0 to 131071 is legal.
- R5: Bits of fields that the opcode does not use never affect legality.
- R6: The flags follow this opcode numbering. halt 0 and syscall 1 use no operand. add 2, sub 3, mul 4, quot 5, mod 6, and 7 and or 8 use both registers and write reg1. neg 9 and not 10 use only reg1 and write it. The compares eql 11, neq 12, lt 13, le 14, gt 15 and ge 16 use both registers and write neither. move 17 uses both registers and writes reg1. load-word 18 uses reg1 and the address and writes reg1. store-word 19 uses reg1 and the address. load-immediate 20 uses reg1 and the immediate and writes reg1. branch 21 uses only the address. For an illegal word all five flags are 0.
- R7: The registered opcode_o, reg1_o, reg2_o and field_o outputs carry the raw fields of the accepted word, whether or not the word is legal.
- R8: A word is accepted on a clock edge where in_valid_i and in_ready_o are both 1. out_valid_o is 1 in the cycle after an acceptance. in_ready_o is 1 when out_valid_o is 0 or out_ready_i is 1. While out_valid_o is 1 and out_ready_i is 0, every output holds its value.
- R9: After reset, out_valid_o is 0 and in_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word present |
| in_ready_o | output | 1 | Block can take a word |
| in_word_i | input | 32 | Instruction word to check |
| out_valid_o | output | 1 | Registered result present |
| out_ready_i | input | 1 | Consumer takes the result |
| legal_o | output | 1 | Word is a legal instruction |
| opcode_o | output | 5 | Opcode field |
| reg1_o | output | 5 | First register selector |
| reg2_o | output | 5 | Second register selector |
| field_o | output | 17 | Address/immediate field |
| use_r1_o | output | 1 | reg1 is used |
| use_r2_o | output | 1 | reg2 is used |
| use_addr_o | output | 1 | Field is a byte address |
| use_imm_o | output | 1 | Field is an immediate |
| writes_r1_o | output | 1 | Instruction overwrites reg1 |

## Verification
The bench sweeps every opcode against every reg1 and reg2 code. The field values are picked so that their low two bits cycle through all four patterns. This covers the rule boundaries: opcodes 21 and 22, register 17 against 18, and registers 15 and 16 as the target of a write. A design that checked an unused selector would reject halt, neg or branch words that carry high register codes. A design that applied the alignment rule to load-immediate would reject odd immediates. A design that banned R16 as a target for every opcode would reject compares and stores that name it. A directed stall sequence holds out_ready_i low, so a design that overwrote its output stage under backpressure would show the second word too early.

// File: rtl/instr_chk_pkg.sv
package instr_chk_pkg;
  localparam int WORD_W = 32;
  localparam int OPC_W  = 5;
  localparam int REG_W  = 5;
  localparam int FLD_W  = 17;

  typedef enum logic [OPC_W-1:0] {
    OP_HALT = 5'd0,  OP_SYSCALL = 5'd1,  OP_ADD = 5'd2,   OP_SUB = 5'd3,
    OP_MUL  = 5'd4,  OP_QUOT    = 5'd5,  OP_MOD = 5'd6,   OP_AND = 5'd7,
    OP_OR   = 5'd8,  OP_NEG     = 5'd9,  OP_NOT = 5'd10,  OP_EQL = 5'd11,
    OP_NEQ  = 5'd12, OP_LT      = 5'd13, OP_LE  = 5'd14,  OP_GT  = 5'd15,
    OP_GE   = 5'd16, OP_MOVE    = 5'd17, OP_LW  = 5'd18,  OP_SW  = 5'd19,
    OP_LI   = 5'd20, OP_BRANCH  = 5'd21
  } op_e;

  typedef struct packed {
    logic use_r1;
    logic use_r2;
    logic use_addr;
    logic use_imm;
    logic writes_r1;
  } use_t;
endpackage

// File: rtl/instr_op_decode.sv
module instr_op_decode
  import instr_chk_pkg::*;
#(
  parameter int NUM_OPS = 22
) (
  input  logic [OPC_W-1:0] opcode_i,
  output logic             known_o,
  output use_t             use_o
);
  localparam logic [OPC_W-1:0] OP_LAST = OPC_W'(NUM_OPS - 1);

  assign known_o = (opcode_i <= OP_LAST);

  always_comb begin
    use_o = '0;
    case (opcode_i)
      OP_ADD, OP_SUB, OP_MUL, OP_QUOT, OP_MOD, OP_AND, OP_OR, OP_MOVE: begin
        use_o.use_r1    = 1'b1;
        use_o.use_r2    = 1'b1;
        use_o.writes_r1 = 1'b1;
      end
      OP_NEG, OP_NOT: begin
        use_o.use_r1    = 1'b1;
        use_o.writes_r1 = 1'b1;
      end
      OP_EQL, OP_NEQ, OP_LT, OP_LE, OP_GT, OP_GE: begin
        use_o.use_r1 = 1'b1;
        use_o.use_r2 = 1'b1;
      end
      OP_LW: begin
        use_o.use_r1    = 1'b1;
        use_o.use_addr  = 1'b1;
        use_o.writes_r1 = 1'b1;
      end
      OP_SW: begin
        use_o.use_r1   = 1'b1;
        use_o.use_addr = 1'b1;
      end
      OP_LI: begin
        use_o.use_r1    = 1'b1;
        use_o.use_imm   = 1'b1;
        use_o.writes_r1 = 1'b1;
      end
      OP_BRANCH: use_o.use_addr = 1'b1;
      default:   use_o = '0;
    endcase
  end
endmodule

// File: rtl/instr_rule_check.sv
module instr_rule_check
  import instr_chk_pkg::*;
#(
  parameter int NUM_REGS   = 18,
  parameter int ALIGN_BITS = 2
) (
  input  logic             known_i,
  input  use_t             use_i,
  input  logic [REG_W-1:0] reg1_i,
  input  logic [REG_W-1:0] reg2_i,
  input  logic [FLD_W-1:0] field_i,
  output logic             legal_o
);
  localparam logic [REG_W-1:0] REG_LIMIT = REG_W'(NUM_REGS);
  // top two register numbers (constant zero, program counter) are read-only
  localparam logic [REG_W-1:0] RO_FIRST  = REG_W'(NUM_REGS - 2);

  logic r1_ok, r2_ok, align_ok;

  assign r1_ok = !use_i.use_r1 ||
                 ((reg1_i < REG_LIMIT) && !(use_i.writes_r1 && (reg1_i >= RO_FIRST)));
  assign r2_ok = !use_i.use_r2 || (reg2_i < REG_LIMIT);

  generate
    if (ALIGN_BITS > 0) begin : g_align
      assign align_ok = !use_i.use_addr || (field_i[ALIGN_BITS-1:0] == '0);
    end else begin : g_no_align
      assign align_ok = 1'b1;
    end
  endgenerate

  assign legal_o = known_i && r1_ok && r2_ok && align_ok;
endmodule

// File: rtl/instr_word_checker.sv
module instr_word_checker
  import instr_chk_pkg::*;
#(
  parameter int NUM_OPS    = 22,
  parameter int NUM_REGS   = 18,
  parameter int ALIGN_BITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_word_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              legal_o,
  output logic [OPC_W-1:0]  opcode_o,
  output logic [REG_W-1:0]  reg1_o,
  output logic [REG_W-1:0]  reg2_o,
  output logic [FLD_W-1:0]  field_o,
  output logic              use_r1_o,
  output logic              use_r2_o,
  output logic              use_addr_o,
  output logic              use_imm_o,
  output logic              writes_r1_o
);
  localparam int R2_LSB  = FLD_W;
  localparam int R1_LSB  = R2_LSB + REG_W;
  localparam int OPC_LSB = R1_LSB + REG_W;

  logic [OPC_W-1:0] opc_w;
  logic [REG_W-1:0] r1_w, r2_w;
  logic [FLD_W-1:0] fld_w;
  logic             known_w, legal_w, take_w;
  use_t             use_w, use_q;

  assign opc_w = in_word_i[OPC_LSB +: OPC_W];
  assign r1_w  = in_word_i[R1_LSB +: REG_W];
  assign r2_w  = in_word_i[R2_LSB +: REG_W];
  assign fld_w = in_word_i[FLD_W-1:0];

  instr_op_decode #(.NUM_OPS(NUM_OPS)) u_dec (
    .opcode_i (opc_w),
    .known_o  (known_w),
    .use_o    (use_w)
  );

  instr_rule_check #(.NUM_REGS(NUM_REGS), .ALIGN_BITS(ALIGN_BITS)) u_rule (
    .known_i (known_w),
    .use_i   (use_w),
    .reg1_i  (r1_w),
    .reg2_i  (r2_w),
    .field_i (fld_w),
    .legal_o (legal_w)
  );

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign take_w     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      legal_o     <= 1'b0;
      opcode_o    <= '0;
      reg1_o      <= '0;
      reg2_o      <= '0;
      field_o     <= '0;
      use_q       <= '0;
    end else if (in_ready_o) begin
      out_valid_o <= in_valid_i;
      if (take_w) begin
        legal_o  <= legal_w;
        opcode_o <= opc_w;
        reg1_o   <= r1_w;
        reg2_o   <= r2_w;
        field_o  <= fld_w;
        use_q    <= legal_w ? use_w : '0;
      end
    end
  end

  assign use_r1_o    = use_q.use_r1;
  assign use_r2_o    = use_q.use_r2;
  assign use_addr_o  = use_q.use_addr;
  assign use_imm_o   = use_q.use_imm;
  assign writes_r1_o = use_q.writes_r1;
endmodule

module instr_word_checker_sva
  import instr_chk_pkg::*;
#(
  parameter int NUM_OPS  = 22,
  parameter int NUM_REGS = 18
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic             legal_o,
  input logic [OPC_W-1:0] opcode_o,
  input logic [REG_W-1:0] reg1_o,
  input logic [REG_W-1:0] reg2_o,
  input logic [FLD_W-1:0] field_o,
  input logic             use_r1_o,
  input logic             use_r2_o,
  input logic             use_addr_o,
  input logic             use_imm_o,
  input logic             writes_r1_o
);
  localparam logic [OPC_W-1:0] OP_LAST  = OPC_W'(NUM_OPS - 1);
  localparam logic [REG_W-1:0] REG_LIM  = REG_W'(NUM_REGS);
  localparam logic [REG_W-1:0] RO_FIRST = REG_W'(NUM_REGS - 2);

  a_r8_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o);
  a_r8_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i && !out_valid_o |=> !out_valid_o);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(legal_o) && $stable(opcode_o)
      && $stable(reg1_o) && $stable(reg2_o) && $stable(field_o));
  a_r1_opcode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && legal_o |-> opcode_o <= OP_LAST);
  a_r2_reg2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && legal_o && use_r2_o |-> reg2_o < REG_LIM);
  a_r3_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && legal_o && writes_r1_o |-> reg1_o < RO_FIRST);
  a_r4_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && legal_o && use_addr_o |-> field_o[1:0] == 2'b00);
  a_r6_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !legal_o |-> !(use_r1_o || use_r2_o || use_addr_o || use_imm_o || writes_r1_o));
  a_r6_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $onehot0({use_addr_o, use_imm_o}));
  a_r6_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && writes_r1_o |-> use_r1_o);
endmodule

bind instr_word_checker instr_word_checker_sva #(.NUM_OPS(NUM_OPS), .NUM_REGS(NUM_REGS)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .legal_o     (legal_o),
  .opcode_o    (opcode_o),
  .reg1_o      (reg1_o),
  .reg2_o      (reg2_o),
  .field_o     (field_o),
  .use_r1_o    (use_r1_o),
  .use_r2_o    (use_r2_o),
  .use_addr_o  (use_addr_o),
  .use_imm_o   (use_imm_o),
  .writes_r1_o (writes_r1_o)
);

// File: tb/instr_word_checker_tb.sv
module instr_word_checker_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [31:0] in_word_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic        legal_o;
  logic [4:0]  opcode_o, reg1_o, reg2_o;
  logic [16:0] field_o;
  logic        use_r1_o, use_r2_o, use_addr_o, use_imm_o, writes_r1_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  instr_word_checker dut_i (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .in_word_i, .out_valid_o, .out_ready_i,
    .legal_o, .opcode_o, .reg1_o, .reg2_o, .field_o,
    .use_r1_o, .use_r2_o, .use_addr_o, .use_imm_o, .writes_r1_o
  );

  function automatic logic [31:0] mk(int op, int r1, int r2, int f);
    return {op[4:0], r1[4:0], r2[4:0], f[16:0]};
  endfunction

  // {legal, use_r1, use_r2, use_addr, use_imm, writes_r1}
  function automatic logic [5:0] expect_dec(int op, int r1, int r2, int f);
    logic u1, u2, ua, ui, wr, lg;
    u1 = (op >= 2 && op <= 20);
    u2 = (op >= 2 && op <= 8) || (op >= 11 && op <= 17);
    ua = (op == 18) || (op == 19) || (op == 21);
    ui = (op == 20);
    wr = (op >= 2 && op <= 10) || op == 17 || op == 18 || op == 20;
    lg = (op <= 21) && !(u1 && r1 >= 18) && !(u2 && r2 >= 18) &&
         !(wr && r1 >= 16) && !(ua && (f % 4) != 0);
    return lg ? {1'b1, u1, u2, ua, ui, wr} : 6'b0;
  endfunction

  function automatic string tag_of(int op, int r1, int r2, int f);
    logic [5:0] full;
    if (op > 21) return "R1";
    full = expect_dec(op, 0, 0, 0);
    if ((full[4] && r1 >= 18) || (full[3] && r2 >= 18)) return "R2";
    if (full[0] && r1 >= 16) return "R3";
    if (full[2] && (f % 4) != 0) return "R4";
    return "R6";
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_word(int op, int r1, int r2, int f, string tag);
    chk(tag, {58'd0, legal_o, use_r1_o, use_r2_o, use_addr_o, use_imm_o, writes_r1_o},
        {58'd0, expect_dec(op, r1, r2, f)}, $sformatf("flags op=%0d r1=%0d r2=%0d f=%0d", op, r1, r2, f));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic int fld_pat(int op, int r1, int r2);
    return (r1 * 4099 + r2 * 517 + op * 13) & 17'h1ffff;
  endfunction

  initial begin
    int pop, pr1, pr2, pf;
    bit pend;
    repeat (3) @(negedge clk_i);
    chk("R9", {63'd0, out_valid_o}, 64'd0, "out_valid in reset");
    chk("R9", {63'd0, in_ready_o}, 64'd1, "in_ready in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R9", {63'd0, out_valid_o}, 64'd0, "out_valid after reset");

    // sweep: all opcodes x all reg1 x all reg2, field low bits cycle
    pend = 1'b0;
    pop = 0; pr1 = 0; pr2 = 0; pf = 0;
    for (int op = 0; op < 32; op++) begin
      for (int r1 = 0; r1 < 32; r1++) begin
        for (int r2 = 0; r2 < 32; r2++) begin
          @(negedge clk_i);
          if (pend) begin
            chk("R8", {63'd0, out_valid_o}, 64'd1, "out_valid after accept");
            check_word(pop, pr1, pr2, pf, tag_of(pop, pr1, pr2, pf));
            chk("R7", {39'd0, opcode_o, reg1_o, reg2_o, field_o},
                {39'd0, mk(pop, pr1, pr2, pf)}, "raw fields");
          end
          pop = op; pr1 = r1; pr2 = r2; pf = fld_pat(op, r1, r2);
          in_word_i  = mk(pop, pr1, pr2, pf);
          in_valid_i = 1'b1;
          pend = 1'b1;
        end
      end
    end
    @(negedge clk_i);
    check_word(pop, pr1, pr2, pf, tag_of(pop, pr1, pr2, pf));
    in_valid_i = 1'b0;
    @(negedge clk_i);
    chk("R8", {63'd0, out_valid_o}, 64'd0, "out_valid drops with in_valid");

    // directed: unused fields full of ones
    begin
      int dir_op[6] = '{0, 1, 9, 21, 17, 11};
      int dir_r1[6] = '{31, 31, 4, 31, 3, 16};
      int dir_r2[6] = '{31, 31, 31, 31, 17, 17};
      int dir_f[6]  = '{131071, 131071, 131071, 65532, 131071, 3};
      for (int k = 0; k < 6; k++) begin
        in_word_i  = mk(dir_op[k], dir_r1[k], dir_r2[k], dir_f[k]);
        in_valid_i = 1'b1;
        @(negedge clk_i);
        chk("R5", {63'd0, legal_o}, 64'd1, $sformatf("unused bits op=%0d", dir_op[k]));
        check_word(dir_op[k], dir_r1[k], dir_r2[k], dir_f[k], "R5");
      end
      in_valid_i = 1'b0;
    end
    // li with odd immediate is legal, lw with same field is not (R4)
    in_word_i = mk(20, 5, 0, 131071); in_valid_i = 1'b1;
    @(negedge clk_i);
    chk("R4", {63'd0, legal_o}, 64'd1, "li odd immediate");
    in_word_i = mk(18, 5, 0, 2002);
    @(negedge clk_i);
    chk("R4", {63'd0, legal_o}, 64'd0, "lw misaligned");
    // sw with R17 as reg1 legal, lw with R17 not (R3)
    in_word_i = mk(19, 17, 0, 2000);
    @(negedge clk_i);
    chk("R3", {63'd0, legal_o}, 64'd1, "sw reads R17");
    in_word_i = mk(18, 17, 0, 2000);
    @(negedge clk_i);
    chk("R3", {63'd0, legal_o}, 64'd0, "lw writes R17");
    in_valid_i = 1'b0;
    @(negedge clk_i);

    // stall: A accepted, B held off while out_ready low
    in_word_i = mk(2, 3, 5, 0); in_valid_i = 1'b1; out_ready_i = 1'b1;
    @(negedge clk_i);
    out_ready_i = 1'b0;
    in_word_i = mk(13, 9, 7, 0);
    #1;
    chk("R8", {63'd0, in_ready_o}, 64'd0, "in_ready low when stalled");
    repeat (2) @(negedge clk_i);
    chk("R8", {59'd0, opcode_o}, 64'd2, "output held under stall");
    chk("R8", {63'd0, out_valid_o}, 64'd1, "out_valid held under stall");
    out_ready_i = 1'b1;
    #1;
    chk("R8", {63'd0, in_ready_o}, 64'd1, "in_ready with out_ready");
    @(negedge clk_i);
    chk("R8", {59'd0, opcode_o}, 64'd13, "B accepted after stall");
    check_word(13, 9, 7, 0, "R8");
    in_valid_i = 1'b0;
    @(negedge clk_i);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (120000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule